// File: doc/BRIEF.md
# Hardware Breakpoint Debug Controller

This block sits beside a datapath and watches a fixed bundle of probed signals. Each probe has its own comparator. At any time a host can load that comparator with a compare value, an operator and an arm bit, and no rebuild of the design is needed. While the controller is running, the armed comparators are ORed together. If any of them matches, the operator-enable line to the datapath drops in that same cycle, which freezes the datapath. On the next clock edge the controller enters debug mode.

In debug mode the datapath stays frozen. The host can then:
- read out which probes matched and the value of every probe at the moment of entry;
- rewrite the breakpoint conditions;
- issue a step, which lets the datapath run for one clock cycle;
- issue a resume, which returns the controller to running mode.

The first running cycle after a resume is blind to matches. This stops a condition that is still true from stopping the datapath again at once.

Top module: `bkpt_debug_ctrl`

## Requirements
- R1: Each armed probe compares its value `p` with its stored argument `a` as unsigned numbers. The operator field selects the test: 0 tests `p == a`, 1 tests `p != a`, 2 tests `p < a` and 3 tests `p > a`.
- R2: A cycle with `cfg_we` high stores the arm bit, operator and argument into the probe entry selected by `cfg_idx`, and into no other entry. The new setting takes effect from the next cycle. Writes are accepted in either mode.
- R3: A probe whose arm bit is 0 never causes a match, whatever its value.
- R4: In running mode, `op_enable` is low in any cycle where at least one armed probe matches and the match is not ignored under R9. Otherwise `op_enable` is high in running mode.
- R5: A match that drops `op_enable` in running mode moves the controller to debug mode at the next rising edge, and `dbg_mode` goes high.
- R6: On entry to debug mode, `hit_vec` records the matching probes (bit i stands for probe i), and the value of every probe is captured. `rd_value` returns the captured value of probe `rd_idx`. Both stay unchanged for the rest of debug mode.
- R7: A `cmd_step` pulse in debug mode raises `op_enable` for exactly one cycle, starting after the next edge. `dbg_mode` stays high throughout, and no new capture takes place.
- R8: A `cmd_resume` in debug mode returns the controller to running mode at the next edge and clears `hit_vec`. When step and resume arrive in the same cycle, resume wins.
- R9: In the first running cycle after a resume, matches are ignored and `op_enable` is high.
- R10: After reset the controller is running, every probe is disarmed, `op_enable` is high and `hit_vec` is zero.
- R11: In debug mode, `op_enable` is low in every cycle except the single step cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_bus | input | NPROBE*PW | Probed values, probe i in bits [i*PW +: PW] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Probe entry to write |
| cfg_en | input | 1 | Arm bit to store |
| cfg_op | input | 2 | Operator to store (0 eq, 1 ne, 2 lt, 3 gt) |
| cfg_arg | input | PW | Compare argument to store |
| cmd_step | input | 1 | Single-step request (debug mode) |
| cmd_resume | input | 1 | Resume request (debug mode) |
| rd_idx | input | IW | Probe whose captured value is read |
| op_enable | output | 1 | Operator enable to the datapath |
| dbg_mode | output | 1 | High while in debug mode |
| hit_vec | output | NPROBE | Sticky record of the probes that matched |
| rd_value | output | PW | Captured value of probe rd_idx |

## Verification
The hardest case to reach is a resume that lands while a breakpoint condition is still true. In that case the one blind cycle must keep `op_enable` high, and the very next cycle must freeze the datapath again. The bench sets this up by holding the matching probe values through a whole debug session. It issues resume and step together, checks `op_enable` in the blind cycle and in the cycle after it, and then checks that the controller re-enters debug mode. Every operator is also swept over every argument and probe value on a 4-bit probe, with the expected match computed arithmetically.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_NE = 2'd1,
        OP_LT = 2'd2,
        OP_GT = 2'd3
    } bkpt_op_e;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_DEBUG = 2'd1,
        MODE_STEP  = 2'd2
    } bkpt_mode_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [PW-1:0] probe,
    input  logic [PW-1:0] arg,
    input  bkpt_op_e      op,
    input  logic          armed,
    output logic          hit
);
    logic match;

    always_comb begin
        unique case (op)
            OP_EQ:   match = (probe == arg);
            OP_NE:   match = (probe != arg);
            OP_LT:   match = (probe <  arg);
            OP_GT:   match = (probe >  arg);
            default: match = 1'b0;
        endcase
        hit = armed & match;
    end
endmodule

// File: rtl/bkpt_cfg_store.sv
module bkpt_cfg_store
    import bkpt_pkg::*;
#(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    localparam int IW    = idx_width(NPROBE)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IW-1:0]      idx,
    input  logic               en_in,
    input  bkpt_op_e           op_in,
    input  logic [PW-1:0]      arg_in,
    output logic [NPROBE-1:0]  en_vec,
    output logic [2*NPROBE-1:0] op_flat,
    output logic [NPROBE*PW-1:0] arg_flat
);
    for (genvar i = 0; i < NPROBE; i++) begin : g_entry
        logic          en_q;
        bkpt_op_e      op_q;
        logic [PW-1:0] arg_q;
        logic          sel;

        assign sel = we && (idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q  <= 1'b0;
                op_q  <= OP_EQ;
                arg_q <= '0;
            end else if (sel) begin
                en_q  <= en_in;
                op_q  <= op_in;
                arg_q <= arg_in;
            end
        end

        assign en_vec[i]           = en_q;
        assign op_flat[2*i +: 2]   = op_q;
        assign arg_flat[i*PW +: PW] = arg_q;
    end
endmodule

// File: rtl/bkpt_mode_fsm.sv
module bkpt_mode_fsm
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any_hit,
    input  logic cmd_step,
    input  logic cmd_resume,
    output logic enter,
    output logic clear,
    output logic op_enable,
    output logic dbg_mode
);
    bkpt_mode_e state_q, state_d;
    logic       guard_q;

    assign enter     = (state_q == MODE_RUN) && !guard_q && any_hit;
    assign clear     = (state_q == MODE_DEBUG) && cmd_resume;
    assign op_enable = ((state_q == MODE_RUN) && !enter) || (state_q == MODE_STEP);
    assign dbg_mode  = (state_q != MODE_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN:   if (enter) state_d = MODE_DEBUG;
            MODE_DEBUG: begin
                if (cmd_resume)    state_d = MODE_RUN;
                else if (cmd_step) state_d = MODE_STEP;
            end
            MODE_STEP:  state_d = MODE_DEBUG;
            default:    state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_RUN;
            guard_q <= 1'b0;
        end else begin
            state_q <= state_d;
            guard_q <= clear;
        end
    end
endmodule

// File: rtl/bkpt_capture.sv
module bkpt_capture
    import bkpt_pkg::*;
#(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    localparam int IW    = idx_width(NPROBE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enter,
    input  logic                 clear,
    input  logic [NPROBE-1:0]    hits,
    input  logic [NPROBE*PW-1:0] probes,
    input  logic [IW-1:0]        rd_idx,
    output logic [NPROBE-1:0]    hit_vec,
    output logic [PW-1:0]        rd_value
);
    logic [NPROBE-1:0]    hit_q;
    logic [NPROBE*PW-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= '0;
            val_q <= '0;
        end else if (enter) begin
            hit_q <= hits;
            val_q <= probes;
        end else if (clear) begin
            hit_q <= '0;
        end
    end

    always_comb begin
        rd_value = '0;
        for (int k = 0; k < NPROBE; k++) begin
            if (rd_idx == IW'(k)) rd_value = val_q[k*PW +: PW];
        end
    end

    assign hit_vec = hit_q;
endmodule

// File: rtl/bkpt_debug_ctrl.sv
module bkpt_debug_ctrl
    import bkpt_pkg::*;
#(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    localparam int IW    = idx_width(NPROBE)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPROBE*PW-1:0] probe_bus,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_idx,
    input  logic                 cfg_en,
    input  logic [1:0]           cfg_op,
    input  logic [PW-1:0]        cfg_arg,
    input  logic                 cmd_step,
    input  logic                 cmd_resume,
    input  logic [IW-1:0]        rd_idx,
    output logic                 op_enable,
    output logic                 dbg_mode,
    output logic [NPROBE-1:0]    hit_vec,
    output logic [PW-1:0]        rd_value
);
    logic [NPROBE-1:0]    en_vec;
    logic [2*NPROBE-1:0]  op_flat;
    logic [NPROBE*PW-1:0] arg_flat;
    logic [NPROBE-1:0]    hits;
    logic                 any_hit, enter, clear;

    bkpt_cfg_store #(.NPROBE(NPROBE), .PW(PW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
        .en_in(cfg_en), .op_in(bkpt_op_e'(cfg_op)), .arg_in(cfg_arg),
        .en_vec(en_vec), .op_flat(op_flat), .arg_flat(arg_flat)
    );

    for (genvar i = 0; i < NPROBE; i++) begin : g_cmp
        bkpt_cmp #(.PW(PW)) u_cmp (
            .probe(probe_bus[i*PW +: PW]),
            .arg(arg_flat[i*PW +: PW]),
            .op(bkpt_op_e'(op_flat[2*i +: 2])),
            .armed(en_vec[i]),
            .hit(hits[i])
        );
    end

    assign any_hit = |hits;

    bkpt_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .any_hit(any_hit),
        .cmd_step(cmd_step), .cmd_resume(cmd_resume),
        .enter(enter), .clear(clear),
        .op_enable(op_enable), .dbg_mode(dbg_mode)
    );

    bkpt_capture #(.NPROBE(NPROBE), .PW(PW)) u_cap (
        .clk(clk), .rst(rst), .enter(enter), .clear(clear),
        .hits(hits), .probes(probe_bus), .rd_idx(rd_idx),
        .hit_vec(hit_vec), .rd_value(rd_value)
    );
endmodule

// File: rtl/bkpt_debug_checker.sv
module bkpt_debug_checker #(
    parameter int NPROBE = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              op_enable,
    input logic              dbg_mode,
    input logic              cmd_step,
    input logic              cmd_resume,
    input logic [NPROBE-1:0] hit_vec
);
    AST_FREEZE_ENTERS_DEBUG: assert property (@(posedge clk) disable iff (rst)
        (!dbg_mode && !op_enable) |=> dbg_mode);                        // R5

    AST_ENTRY_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_mode) |-> (hit_vec != '0));                           // R6

    AST_HITS_HELD: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && $past(dbg_mode)) |-> $stable(hit_vec));            // R6

    AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && op_enable) |=> (dbg_mode && !op_enable));          // R7

    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && !op_enable && cmd_resume) |=>
            (!dbg_mode && op_enable && hit_vec == '0));                 // R8

    AST_DEBUG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && !op_enable && !cmd_step && !cmd_resume) |=>
            (dbg_mode && !op_enable));                                  // R11
endmodule

bind bkpt_debug_ctrl bkpt_debug_checker #(.NPROBE(NPROBE)) u_chk (
    .clk(clk), .rst(rst), .op_enable(op_enable), .dbg_mode(dbg_mode),
    .cmd_step(cmd_step), .cmd_resume(cmd_resume), .hit_vec(hit_vec)
);

// File: tb/tb_bkpt_debug_ctrl.sv
`timescale 1ns/1ps
module tb_bkpt_debug_ctrl;
    localparam int NP = 4;
    localparam int PW = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP*PW-1:0] probe_bus = '0;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic cfg_en = 1'b0;
    logic [1:0] cfg_op = '0;
    logic [PW-1:0] cfg_arg = '0;
    logic cmd_step = 1'b0, cmd_resume = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic op_enable, dbg_mode;
    logic [NP-1:0] hit_vec;
    logic [PW-1:0] rd_value;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bkpt_debug_ctrl #(.NPROBE(NP), .PW(PW)) dut (
        .clk(clk), .rst(rst), .probe_bus(probe_bus), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_arg(cfg_arg),
        .cmd_step(cmd_step), .cmd_resume(cmd_resume), .rd_idx(rd_idx),
        .op_enable(op_enable), .dbg_mode(dbg_mode), .hit_vec(hit_vec),
        .rd_value(rd_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model(input int op, input int a, input int p);
        case (op)
            0: return p == a;
            1: return p != a;
            2: return p < a;
            default: return p > a;
        endcase
    endfunction

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input int idx, input bit en, input int op, input int arg);
        cfg_idx = IW'(idx); cfg_en = en; cfg_op = 2'(op); cfg_arg = PW'(arg);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_probes(input int p0, input int p1, input int p2, input int p3);
        probe_bus = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 op_enable", op_enable, 1);
        chk("R10 dbg_mode", dbg_mode, 0);
        chk("R10 hit_vec", hit_vec, 0);

        // R1 / R4 / R5 / R6 exhaustive sweep on probe 0
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int v = 0; v < 16; v++) begin
                    bit e;
                    e = model(op, a, v);
                    set_probes(v, 0, 0, 0);
                    rd_idx = 2'd0;
                    wr(0, 1'b1, op, a);
                    chk("R1 R4 op_enable vs operator", op_enable, e ? 0 : 1);
                    @(negedge clk);
                    chk("R5 dbg_mode", dbg_mode, e);
                    if (e) begin
                        chk("R6 hit_vec", hit_vec, 1);
                        chk("R6 rd_value", rd_value, v);
                        cmd_resume = 1'b1;
                        wr(0, 1'b0, 0, 0);
                        cmd_resume = 1'b0;
                        @(negedge clk);
                    end else begin
                        wr(0, 1'b0, 0, 0);
                    end
                end
            end
        end

        // R3 disarmed probe never matches
        set_probes(7, 7, 7, 7);
        wr(0, 1'b0, 0, 7);
        @(negedge clk);
        chk("R3 op_enable disarmed", op_enable, 1);
        chk("R3 dbg_mode disarmed", dbg_mode, 0);

        // R6 two probes matching at once, full capture
        set_probes(0, 0, 7, 0);
        wr(1, 1'b1, 0, 5);
        wr(2, 1'b1, 2, 1);
        chk("R4 no match yet", op_enable, 1);
        set_probes(3, 5, 0, 9);
        #1;
        chk("R4 freeze same cycle", op_enable, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R5 entered debug", dbg_mode, 1);
        chk("R6 hit_vec two probes", hit_vec, 6);
        for (int k = 0; k < 4; k++) begin
            rd_idx = 2'(k);
            #1;
            chk("R6 captured value", rd_value, (k == 0) ? 3 : (k == 1) ? 5 : (k == 2) ? 0 : 9);
        end
        set_probes(15, 15, 15, 15);
        @(negedge clk);
        rd_idx = 2'd1;
        #1;
        chk("R6 capture held", rd_value, 5);
        chk("R6 hit_vec held", hit_vec, 6);
        chk("R11 frozen in debug", op_enable, 0);

        // R7 single step
        cmd_step = 1'b1;
        @(negedge clk);
        cmd_step = 1'b0;
        chk("R7 step enables", op_enable, 1);
        chk("R7 still debug", dbg_mode, 1);
        @(negedge clk);
        chk("R7 step lasts one cycle", op_enable, 0);
        chk("R7 debug kept", dbg_mode, 1);
        chk("R7 no recapture", hit_vec, 6);

        // R8 / R9 resume with condition still true; resume beats step
        set_probes(3, 5, 0, 9);
        cmd_resume = 1'b1; cmd_step = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0; cmd_step = 1'b0;
        chk("R8 back to running", dbg_mode, 0);
        chk("R8 hit_vec cleared", hit_vec, 0);
        chk("R9 blind cycle enables", op_enable, 1);
        @(negedge clk);
        chk("R9 rearmed freeze", op_enable, 0);
        @(negedge clk);
        chk("R5 reentered debug", dbg_mode, 1);
        chk("R6 hit_vec again", hit_vec, 6);

        // R2 reconfigure during debug, then select a single entry
        wr(1, 1'b0, 0, 5);
        wr(2, 1'b0, 2, 1);
        cmd_resume = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0;
        @(negedge clk);
        chk("R2 disarm in debug effective", op_enable, 1);
        @(negedge clk);
        chk("R2 stays running", dbg_mode, 0);
        wr(3, 1'b1, 3, 8);
        chk("R2 entry 3 armed", op_enable, 0);
        @(negedge clk);
        chk("R2 only entry 3", hit_vec, 8);
        cmd_resume = 1'b1;
        wr(3, 1'b0, 0, 0);
        cmd_resume = 1'b0;
        @(negedge clk);
        chk("R8 final running", dbg_mode, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule